// File: doc/BRIEF.md
# Banked Address and Stack Sequencer

This block produces the bus address and the read/write strobe for each memory cycle of a processor with a 24-bit address space split into a bank byte and a 16-bit offset. Each clock a command code arrives. The block answers with one registered bus cycle, or with an update of its own address state.

It holds four pieces of state. The data address register is loaded from an absolute operand or from an indexed-indirect pointer, and it steps up or down inside its bank. The stack pointer is pushed and pulled, and in emulation mode it stays inside page one. The program bank and program counter are loaded by long jumps and calls. The return counter keeps the old program counter so that a later cycle can push it.

The block does no instruction decode and has no data path. A sequencer upstream issues one command per cycle and supplies the operand, the X index, the data bank byte and the two mode flags.

Top module: `bank_addr_seq`

## Requirements
- R1: After reset (rst_n low) the outputs read: data_addr_o = 0, sp_o = 0x01FF, pbank_o = 0, pc_o = 0, ret_pc_o = 0, bus_addr_o = 0, bus_we_o = 0, bus_vld_o = 0.
- R2: All state and bus outputs change on the clock edge that samples cmd_i and are visible in the next cycle. Codes 3 to 10 are bus commands and give bus_vld_o = 1 for exactly that cycle. Every other code gives bus_vld_o = 0 and bus_we_o = 0, and leaves bus_addr_o unchanged.
- R3: Code 1 (absolute load) sets data_addr_o = {dbank_i, operand_i[15:0]}.
- R4: Code 2 (indexed-indirect pointer) sets data_addr_o = {8'h00, (operand_i[15:0] + X') mod 65536}. X' is x_i[7:0] zero-extended when x8_i = 1, and x_i otherwise.
- R5: Code 3 (read) and code 5 (write) drive data_addr_o onto bus_addr_o and leave data_addr_o unchanged. bus_we_o is 0 for the read and 1 for the write.
- R6: Code 4 (read) and code 6 (write) drive the current data_addr_o and then add 1 to its bits 15:0 modulo 65536. Bits 23:16 stay unchanged.
- R7: Code 7 (write) drives the current data_addr_o and then subtracts 1 from its bits 15:0 modulo 65536. Bits 23:16 stay unchanged.
- R8: A stack bus address is {8'h00, 8'h01, sp[7:0]} when emu_i = 1 and {8'h00, sp[15:0]} when emu_i = 0.
- R9: Code 8 (push) drives the stack address of the old pointer with bus_we_o = 1, then decrements sp_o.
- R10: Code 9 (pull) first increments sp_o, then drives the stack address of the new pointer with bus_we_o = 0.
- R11: With emu_i = 1, a push, a pull or a pointer load leaves sp_o[15:8] = 0x01, and the low byte wraps modulo 256.
- R12: Code 10 (dummy stack cycle) drives the stack address with bus_we_o = 0 and leaves sp_o unchanged.
- R13: Code 11 sets pbank_o = operand_i[23:16] and pc_o = operand_i[15:0]. Code 12 does the same and also copies the old pc_o into ret_pc_o. Code 13 sets pc_o = operand_i[15:0] and copies the old pc_o into ret_pc_o, and leaves pbank_o as it was.
- R14: Code 14 loads sp_o from operand_i[15:0]. The high byte is forced per R11 when emu_i = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 4 | Command code for this cycle |
| operand_i | input | 24 | Operand (address, jump target, or pointer value) |
| x_i | input | 16 | X index register value |
| dbank_i | input | 8 | Data bank byte |
| emu_i | input | 1 | Emulation mode, 1 = stack confined to page one |
| x8_i | input | 1 | Index width, 1 = 8-bit X |
| bus_addr_o | output | 24 | Registered bus address |
| bus_we_o | output | 1 | Registered write strobe |
| bus_vld_o | output | 1 | One-cycle bus cycle valid |
| data_addr_o | output | 24 | Data address register |
| sp_o | output | 16 | Stack pointer |
| pbank_o | output | 8 | Program bank |
| pc_o | output | 16 | Program counter |
| ret_pc_o | output | 16 | Saved program counter for a call |

## Verification
The assertions check on every cycle the properties that hold for any history. The bank byte does not move on an increment or a decrement, and the auto-increment drives the old address and then steps it. In native mode the push and the pull update the pointer in opposite orders. The emulation stack address stays on page one, the dummy cycle leaves the pointer alone, and non-bus codes raise no strobe. Absolute and indirect address formation, the index-width mask, the wrap at the edges of the bank and of page one, and the bank and return values of jumps and calls depend on operand values. Only the bench's scenarios, compared against its model, show those.

// File: rtl/bas_pkg.sv
package bas_pkg;

   typedef enum logic [3:0] {
      CMD_NOP       = 4'd0,
      CMD_LD_ABS    = 4'd1,
      CMD_LD_INDIR  = 4'd2,
      CMD_RD        = 4'd3,
      CMD_RD_INC    = 4'd4,
      CMD_WR        = 4'd5,
      CMD_WR_INC    = 4'd6,
      CMD_WR_DEC    = 4'd7,
      CMD_PUSH      = 4'd8,
      CMD_PULL      = 4'd9,
      CMD_STK_DUMMY = 4'd10,
      CMD_JMP_LONG  = 4'd11,
      CMD_CALL_LONG = 4'd12,
      CMD_CALL      = 4'd13,
      CMD_LD_SP     = 4'd14,
      CMD_RSVD      = 4'd15
   } bas_cmd_e;

   function automatic logic is_data_cycle(bas_cmd_e c);
      return c inside {CMD_RD, CMD_RD_INC, CMD_WR, CMD_WR_INC, CMD_WR_DEC};
   endfunction

   function automatic logic is_stack_cycle(bas_cmd_e c);
      return c inside {CMD_PUSH, CMD_PULL, CMD_STK_DUMMY};
   endfunction

   function automatic logic is_write_cycle(bas_cmd_e c);
      return c inside {CMD_WR, CMD_WR_INC, CMD_WR_DEC, CMD_PUSH};
   endfunction

endpackage

// File: rtl/bas_daddr.sv
module bas_daddr
   import bas_pkg::*;
#(
   parameter int BANK_W   = 8,
   parameter int OFF_W    = 16,
   parameter int IDX_W    = 16,
   parameter int NARROW_W = 8,
   localparam int ADDR_W  = BANK_W + OFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  bas_cmd_e          cmd,
   input  logic [OFF_W-1:0]  offset_in,
   input  logic [IDX_W-1:0]  x_in,
   input  logic              x_narrow,
   input  logic [BANK_W-1:0] bank_in,
   output logic [ADDR_W-1:0] daddr_q
);

   logic [IDX_W-1:0]  x_eff;
   logic [ADDR_W-1:0] daddr_n;
   logic [OFF_W-1:0]  off_cur;
   logic [BANK_W-1:0] bank_cur;

   generate
      if (IDX_W > NARROW_W) begin : g_mask
         assign x_eff = x_narrow ? {{(IDX_W-NARROW_W){1'b0}}, x_in[NARROW_W-1:0]} : x_in;
      end else begin : g_pass
         logic unused_narrow;
         assign unused_narrow = x_narrow;
         assign x_eff = x_in;
      end
   endgenerate

   assign off_cur  = daddr_q[OFF_W-1:0];
   assign bank_cur = daddr_q[ADDR_W-1:OFF_W];

   always_comb begin
      daddr_n = daddr_q;
      case (cmd)
         CMD_LD_ABS:             daddr_n = {bank_in, offset_in};
         CMD_LD_INDIR:           daddr_n = {{BANK_W{1'b0}}, OFF_W'(offset_in + OFF_W'(x_eff))};
         CMD_RD_INC, CMD_WR_INC: daddr_n = {bank_cur, OFF_W'(off_cur + OFF_W'(1))};
         CMD_WR_DEC:             daddr_n = {bank_cur, OFF_W'(off_cur - OFF_W'(1))};
         default:                daddr_n = daddr_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) daddr_q <= '0;
      else        daddr_q <= daddr_n;
   end

endmodule

// File: rtl/bas_stack.sv
module bas_stack
   import bas_pkg::*;
#(
   parameter int              SP_W       = 16,
   parameter int              PAGE_W     = 8,
   parameter int              ADDR_W     = 24,
   parameter int              STACK_PAGE = 1,
   parameter logic [SP_W-1:0] SP_RESET   = 16'h01FF,
   localparam int             HI_W       = SP_W - PAGE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  bas_cmd_e          cmd,
   input  logic              emu,
   input  logic [SP_W-1:0]   sp_load,
   output logic [SP_W-1:0]   sp_q,
   output logic [ADDR_W-1:0] stk_addr
);

   localparam logic [HI_W-1:0] PAGE_HI = HI_W'(STACK_PAGE);

   logic [SP_W-1:0] sp_n;
   logic [SP_W-1:0] sp_up;
   logic [SP_W-1:0] sp_dn;

   function automatic logic [SP_W-1:0] confine(logic [SP_W-1:0] v, logic e);
      return e ? {PAGE_HI, v[PAGE_W-1:0]} : v;
   endfunction

   function automatic logic [ADDR_W-1:0] to_bus(logic [SP_W-1:0] v, logic e);
      return ADDR_W'(confine(v, e));
   endfunction

   assign sp_up = SP_W'(sp_q + SP_W'(1));
   assign sp_dn = SP_W'(sp_q - SP_W'(1));

   always_comb begin
      sp_n     = sp_q;
      stk_addr = to_bus(sp_q, emu);
      case (cmd)
         CMD_PUSH: sp_n = confine(sp_dn, emu);
         CMD_PULL: begin
            sp_n     = confine(sp_up, emu);
            stk_addr = to_bus(sp_up, emu);
         end
         CMD_LD_SP: sp_n = confine(sp_load, emu);
         default:   sp_n = sp_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sp_q <= SP_RESET;
      else        sp_q <= sp_n;
   end

endmodule

// File: rtl/bas_flow.sv
module bas_flow
   import bas_pkg::*;
#(
   parameter int BANK_W = 8,
   parameter int OFF_W  = 16,
   localparam int ADDR_W = BANK_W + OFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  bas_cmd_e          cmd,
   input  logic [ADDR_W-1:0] target,
   output logic [BANK_W-1:0] pbank_q,
   output logic [OFF_W-1:0]  pc_q,
   output logic [OFF_W-1:0]  ret_q
);

   logic load_bank;
   logic load_pc;
   logic save_ret;

   assign load_bank = cmd inside {CMD_JMP_LONG, CMD_CALL_LONG};
   assign load_pc   = cmd inside {CMD_JMP_LONG, CMD_CALL_LONG, CMD_CALL};
   assign save_ret  = cmd inside {CMD_CALL_LONG, CMD_CALL};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pbank_q <= '0;
         pc_q    <= '0;
         ret_q   <= '0;
      end else begin
         if (load_bank) pbank_q <= target[ADDR_W-1:OFF_W];
         if (load_pc)   pc_q    <= target[OFF_W-1:0];
         if (save_ret)  ret_q   <= pc_q;
      end
   end

endmodule

// File: rtl/bank_addr_seq.sv
module bank_addr_seq
   import bas_pkg::*;
#(
   parameter int BANK_W     = 8,
   parameter int OFF_W      = 16,
   parameter int IDX_W      = 16,
   parameter int NARROW_W   = 8,
   parameter int PAGE_W     = 8,
   parameter int STACK_PAGE = 1,
   parameter logic [OFF_W-1:0] SP_RESET = 16'h01FF,
   localparam int ADDR_W    = BANK_W + OFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        cmd_i,
   input  logic [ADDR_W-1:0] operand_i,
   input  logic [IDX_W-1:0]  x_i,
   input  logic [BANK_W-1:0] dbank_i,
   input  logic              emu_i,
   input  logic              x8_i,
   output logic [ADDR_W-1:0] bus_addr_o,
   output logic              bus_we_o,
   output logic              bus_vld_o,
   output logic [ADDR_W-1:0] data_addr_o,
   output logic [OFF_W-1:0]  sp_o,
   output logic [BANK_W-1:0] pbank_o,
   output logic [OFF_W-1:0]  pc_o,
   output logic [OFF_W-1:0]  ret_pc_o
);

   generate
      if (IDX_W > OFF_W) begin : g_bad_idx
         $error("bank_addr_seq: IDX_W must not exceed OFF_W");
      end
      if (PAGE_W >= OFF_W || PAGE_W < 1) begin : g_bad_page
         $error("bank_addr_seq: PAGE_W must lie in 1..OFF_W-1");
      end
      if (NARROW_W < 1) begin : g_bad_narrow
         $error("bank_addr_seq: NARROW_W must be positive");
      end
      if (STACK_PAGE >= (1 << (OFF_W - PAGE_W))) begin : g_bad_stk
         $error("bank_addr_seq: STACK_PAGE does not fit above the page");
      end
   endgenerate

   bas_cmd_e          cmd;
   logic [ADDR_W-1:0] daddr_q;
   logic [ADDR_W-1:0] stk_addr;
   logic [ADDR_W-1:0] bus_addr_q;
   logic              bus_we_q;
   logic              bus_vld_q;
   logic              is_data;
   logic              is_stack;

   assign cmd      = bas_cmd_e'(cmd_i);
   assign is_data  = is_data_cycle(cmd);
   assign is_stack = is_stack_cycle(cmd);

   bas_daddr #(
      .BANK_W   (BANK_W),
      .OFF_W    (OFF_W),
      .IDX_W    (IDX_W),
      .NARROW_W (NARROW_W)
   ) u_daddr (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd      (cmd),
      .offset_in(operand_i[OFF_W-1:0]),
      .x_in     (x_i),
      .x_narrow (x8_i),
      .bank_in  (dbank_i),
      .daddr_q  (daddr_q)
   );

   bas_stack #(
      .SP_W      (OFF_W),
      .PAGE_W    (PAGE_W),
      .ADDR_W    (ADDR_W),
      .STACK_PAGE(STACK_PAGE),
      .SP_RESET  (SP_RESET)
   ) u_stack (
      .clk     (clk),
      .rst_n   (rst_n),
      .cmd     (cmd),
      .emu     (emu_i),
      .sp_load (operand_i[OFF_W-1:0]),
      .sp_q    (sp_o),
      .stk_addr(stk_addr)
   );

   bas_flow #(
      .BANK_W(BANK_W),
      .OFF_W (OFF_W)
   ) u_flow (
      .clk    (clk),
      .rst_n  (rst_n),
      .cmd    (cmd),
      .target (operand_i),
      .pbank_q(pbank_o),
      .pc_q   (pc_o),
      .ret_q  (ret_pc_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_addr_q <= '0;
         bus_we_q   <= 1'b0;
         bus_vld_q  <= 1'b0;
      end else begin
         bus_vld_q <= is_data | is_stack;
         bus_we_q  <= is_write_cycle(cmd);
         if (is_data)       bus_addr_q <= daddr_q;
         else if (is_stack) bus_addr_q <= stk_addr;
      end
   end

   assign bus_addr_o  = bus_addr_q;
   assign bus_we_o    = bus_we_q;
   assign bus_vld_o   = bus_vld_q;
   assign data_addr_o = daddr_q;

endmodule

// File: rtl/bas_checker.sv
module bas_checker #(
   parameter int OFF_W      = 16,
   parameter int ADDR_W     = 24,
   parameter int PAGE_W     = 8,
   parameter int STACK_PAGE = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [3:0]        cmd_i,
   input logic              emu_i,
   input logic [ADDR_W-1:0] bus_addr_o,
   input logic              bus_we_o,
   input logic              bus_vld_o,
   input logic [ADDR_W-1:0] data_addr_o,
   input logic [OFF_W-1:0]  sp_o
);

   localparam int HI_W = OFF_W - PAGE_W;

   // R6 / R7: stepping never touches the bank byte
   assert_bank_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_i inside {4'd4, 4'd6, 4'd7}) |=>
         data_addr_o[ADDR_W-1:OFF_W] == $past(data_addr_o[ADDR_W-1:OFF_W]));

   // R6: old address on the bus, then incremented offset
   assert_inc_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_i == 4'd4) |=> (bus_addr_o == $past(data_addr_o)) && !bus_we_o &&
         (data_addr_o[OFF_W-1:0] == OFF_W'($past(data_addr_o[OFF_W-1:0]) + OFF_W'(1))));

   // R7: decrementing store
   assert_dec_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_i == 4'd7) |=> (bus_addr_o == $past(data_addr_o)) && bus_we_o &&
         (data_addr_o[OFF_W-1:0] == OFF_W'($past(data_addr_o[OFF_W-1:0]) - OFF_W'(1))));

   // R9: native push writes at old pointer then decrements
   assert_push_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_i == 4'd8 && !emu_i) |=> bus_we_o && bus_vld_o &&
         (bus_addr_o == ADDR_W'($past(sp_o))) && (sp_o == OFF_W'($past(sp_o) - OFF_W'(1))));

   // R10: native pull increments first, then reads at new pointer
   assert_pull_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_i == 4'd9 && !emu_i) |=> !bus_we_o && bus_vld_o &&
         (sp_o == OFF_W'($past(sp_o) + OFF_W'(1))) && (bus_addr_o == ADDR_W'(sp_o)));

   // R8: emulation stack cycles stay on the stack page
   assert_emu_page_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((cmd_i inside {4'd8, 4'd9, 4'd10}) && emu_i) |=>
         bus_addr_o[ADDR_W-1:PAGE_W] == (ADDR_W-PAGE_W)'(STACK_PAGE));

   // R11: pointer high byte pinned after emulation push or pull
   assert_emu_sp_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ((cmd_i inside {4'd8, 4'd9}) && emu_i) |=>
         sp_o[OFF_W-1:PAGE_W] == HI_W'(STACK_PAGE));

   // R12: dummy stack cycle reads and keeps the pointer
   assert_dummy_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_i == 4'd10) |=> $stable(sp_o) && !bus_we_o && bus_vld_o);

   // R2: non-bus codes raise no strobe and hold the address
   assert_no_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_i inside {[4'd3:4'd10]}) |=> !bus_vld_o && !bus_we_o && $stable(bus_addr_o));

endmodule

bind bank_addr_seq bas_checker #(
   .OFF_W     (OFF_W),
   .ADDR_W    (ADDR_W),
   .PAGE_W    (PAGE_W),
   .STACK_PAGE(STACK_PAGE)
) u_bas_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cmd_i      (cmd_i),
   .emu_i      (emu_i),
   .bus_addr_o (bus_addr_o),
   .bus_we_o   (bus_we_o),
   .bus_vld_o  (bus_vld_o),
   .data_addr_o(data_addr_o),
   .sp_o       (sp_o)
);

// File: tb/sim_bank_addr_seq.sv
module sim_bank_addr_seq;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  cmd_i = 4'd0;
   logic [23:0] operand_i = '0;
   logic [15:0] x_i = '0;
   logic [7:0]  dbank_i = '0;
   logic        emu_i = 1'b1;
   logic        x8_i = 1'b1;
   logic [23:0] bus_addr_o;
   logic        bus_we_o;
   logic        bus_vld_o;
   logic [23:0] data_addr_o;
   logic [15:0] sp_o;
   logic [7:0]  pbank_o;
   logic [15:0] pc_o;
   logic [15:0] ret_pc_o;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   logic [23:0] m_da, m_ba;
   logic [15:0] m_sp, m_pc, m_ret;
   logic [7:0]  m_pb;
   logic        m_we, m_vld;

   always #(CLK_PERIOD/2) clk = ~clk;

   bank_addr_seq u0 (
      .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .operand_i(operand_i), .x_i(x_i),
      .dbank_i(dbank_i), .emu_i(emu_i), .x8_i(x8_i), .bus_addr_o(bus_addr_o),
      .bus_we_o(bus_we_o), .bus_vld_o(bus_vld_o), .data_addr_o(data_addr_o),
      .sp_o(sp_o), .pbank_o(pbank_o), .pc_o(pc_o), .ret_pc_o(ret_pc_o)
   );

   function automatic logic [15:0] pin_sp(logic [15:0] v, logic e);
      return e ? {8'h01, v[7:0]} : v;
   endfunction

   function automatic logic [23:0] stk_bus(logic [15:0] v, logic e);
      return {8'h00, pin_sp(v, e)};
   endfunction

   function automatic string tag_of(logic [3:0] c);
      case (c)
         4'd1: return "R3";
         4'd2: return "R4";
         4'd3, 4'd5: return "R5";
         4'd4, 4'd6: return "R6";
         4'd7: return "R7";
         4'd8: return "R9";
         4'd9: return "R10";
         4'd10: return "R12";
         4'd11, 4'd12, 4'd13: return "R13";
         4'd14: return "R14";
         default: return "R2";
      endcase
   endfunction

   task automatic chk(string tag, string what, logic [23:0] act, logic [23:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic compare_all(string tag);
      chk(tag, "data_addr", data_addr_o, m_da);
      chk(tag, "sp", 24'(sp_o), 24'(m_sp));
      chk(tag, "pbank", 24'(pbank_o), 24'(m_pb));
      chk(tag, "pc", 24'(pc_o), 24'(m_pc));
      chk(tag, "ret_pc", 24'(ret_pc_o), 24'(m_ret));
      chk(tag, "bus_addr", bus_addr_o, m_ba);
      chk(tag, "bus_we", 24'(bus_we_o), 24'(m_we));
      chk(tag, "bus_vld", 24'(bus_vld_o), 24'(m_vld));
   endtask

   // Issue one command at a falling edge, update the model, compare at the next falling edge.
   task automatic issue(logic [3:0] c, logic [23:0] op, logic [15:0] x, logic [7:0] db,
                        logic e, logic x8, string tag);
      logic [15:0] xe;
      cmd_i = c; operand_i = op; x_i = x; dbank_i = db; emu_i = e; x8_i = x8;
      m_vld = (c >= 4'd3 && c <= 4'd10);
      m_we  = (c >= 4'd5 && c <= 4'd8);
      case (c)
         4'd1: m_da = {db, op[15:0]};
         4'd2: begin
            xe = x8 ? {8'h00, x[7:0]} : x;
            m_da = {8'h00, 16'(op[15:0] + xe)};
         end
         4'd3, 4'd5: m_ba = m_da;
         4'd4, 4'd6: begin m_ba = m_da; m_da = {m_da[23:16], 16'(m_da[15:0] + 16'd1)}; end
         4'd7: begin m_ba = m_da; m_da = {m_da[23:16], 16'(m_da[15:0] - 16'd1)}; end
         4'd8: begin m_ba = stk_bus(m_sp, e); m_sp = pin_sp(16'(m_sp - 16'd1), e); end
         4'd9: begin m_sp = pin_sp(16'(m_sp + 16'd1), e); m_ba = stk_bus(m_sp, e); end
         4'd10: m_ba = stk_bus(m_sp, e);
         4'd11: begin m_pb = op[23:16]; m_pc = op[15:0]; end
         4'd12: begin m_ret = m_pc; m_pb = op[23:16]; m_pc = op[15:0]; end
         4'd13: begin m_ret = m_pc; m_pc = op[15:0]; end
         4'd14: m_sp = pin_sp(op[15:0], e);
         default: ;
      endcase
      @(negedge clk);
      compare_all(tag);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240517));
      m_da = '0; m_ba = '0; m_sp = 16'h01FF; m_pc = '0; m_ret = '0; m_pb = '0;
      m_we = 1'b0; m_vld = 1'b0;
      repeat (3) @(negedge clk);
      compare_all("R1");
      rst_n = 1'b1;
      @(negedge clk);

      // R6: increment wraps inside the bank
      issue(4'd1, 24'h00FFFF, 16'h0, 8'h12, 1'b0, 1'b0, "R3");
      issue(4'd4, 24'h0, 16'h0, 8'h0, 1'b0, 1'b0, "R6");
      // R7: decrement wraps inside the bank
      issue(4'd1, 24'h000000, 16'h0, 8'h34, 1'b0, 1'b0, "R3");
      issue(4'd7, 24'h0, 16'h0, 8'h0, 1'b0, 1'b0, "R7");
      // R4: narrow index masks X, wide index uses all of it
      issue(4'd2, 24'h55FFF0, 16'hABCD, 8'h77, 1'b0, 1'b1, "R4");
      issue(4'd2, 24'h55FFF0, 16'hABCD, 8'h77, 1'b0, 1'b0, "R4");
      issue(4'd5, 24'h0, 16'h0, 8'h0, 1'b0, 1'b0, "R5");
      // R2: non-bus code holds the address
      issue(4'd0, 24'hFFFFFF, 16'hFFFF, 8'hFF, 1'b0, 1'b0, "R2");
      // R11: emulation push wraps within page one
      issue(4'd14, 24'h00AB00, 16'h0, 8'h0, 1'b1, 1'b1, "R14");
      issue(4'd8, 24'h0, 16'h0, 8'h0, 1'b1, 1'b1, "R11");
      issue(4'd9, 24'h0, 16'h0, 8'h0, 1'b1, 1'b1, "R11");
      // R10: native pull wraps the full pointer
      issue(4'd14, 24'h00FFFF, 16'h0, 8'h0, 1'b0, 1'b0, "R14");
      issue(4'd9, 24'h0, 16'h0, 8'h0, 1'b0, 1'b0, "R10");
      issue(4'd8, 24'h0, 16'h0, 8'h0, 1'b0, 1'b0, "R9");
      // R8: emulation dummy on a native-high pointer still maps to page one
      issue(4'd14, 24'h003456, 16'h0, 8'h0, 1'b0, 1'b0, "R14");
      issue(4'd10, 24'h0, 16'h0, 8'h0, 1'b1, 1'b1, "R8");
      issue(4'd10, 24'h0, 16'h0, 8'h0, 1'b0, 1'b0, "R12");
      // R13: long jump, long call, short call
      issue(4'd11, 24'hC01234, 16'h0, 8'h0, 1'b0, 1'b0, "R13");
      issue(4'd12, 24'h7E8000, 16'h0, 8'h0, 1'b0, 1'b0, "R13");
      issue(4'd13, 24'h99ABCD, 16'h0, 8'h0, 1'b0, 1'b0, "R13");

      for (int i = 0; i < 4000; i++) begin
         logic [3:0] c;
         c = 4'($urandom_range(0, 15));
         issue(c, 24'($urandom), 16'($urandom), 8'($urandom),
               1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), tag_of(c));
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule